// File: doc/BRIEF.md
# Segmented-Paging Address Translation Walker

This block turns a 32-bit logical address into a physical address. It walks two levels of tables that sit in memory. The logical address carries a segment index, a page index within that segment and a byte offset within a 4 KB page. A process-specific base register points at the segment table. Each segment entry gives the base of that segment's page table and the segment's length in pages. Each page entry gives a frame number and a valid flag. The block returns either the physical address or a 2-bit fault code.

Requests arrive on a valid/ready stream. The block accepts a request only when it is idle and no result is waiting, so `req_ready` stays low for the whole walk and for as long as a result goes unclaimed. This applies back-pressure to the requester. The result stream holds its payload stable while `res_ready` is low. Word reads go out on a request/response memory port. A read request holds its address until `mem_req_ready`. Exactly one read is outstanding at a time, and its response is taken whenever `mem_rsp_valid` rises. The data access at the translated address is left to the requester.

Top module: `segpage_walker`

## Requirements
- R1: The logical address splits into segment index bits 31:24, page index bits 23:12 and offset bits 11:0. A successful walk returns `{frame[19:0], offset[11:0]}` with fault code 0.
- R2: The segment entry is two words. The page-table base is read at `base + seg*8` and the length in pages at `base + seg*8 + 4`. The page entry is read at `page_table_base + page*4`.
- R3: Reads happen in a fixed order: segment base word, then segment length word, then page entry. At most one read is outstanding. `mem_req_valid` and `mem_req_addr` stay stable until `mem_req_ready` is high, and no read is requested while a result is pending.
- R4: If the page index is greater than or equal to the segment length, the walk ends with fault code 1 (bounds) and the page table is never read. A zero-length segment therefore faults for every page.
- R5: A page entry whose bit 31 is clear ends the walk with fault code 2 (page invalid). Its frame comes from bits 19:0. Any faulted result carries physical address 0.
- R6: `base_wr_en` loads `base_wr_data` into the base register. A walk uses the value held when its request was accepted, so a write during a walk, or in the cycle of acceptance, applies only to later requests.
- R7: `req_ready` is high only when no walk is in progress and no result is pending. It drops in the cycle after a request is accepted.
- R8: Once `res_valid` rises, it stays high with `res_paddr` and `res_fault` unchanged until a cycle with `res_ready` high. The code 3 is never produced.
- R9: After reset, `req_ready` is high and `res_valid` and `mem_req_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base_wr_en | input | 1 | Load the segment table base register |
| base_wr_data | input | 32 | New segment table base address |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker can accept a request |
| req_laddr | input | 32 | Logical address to translate |
| mem_req_valid | output | 1 | Word read request valid |
| mem_req_ready | input | 1 | Memory accepts the read request |
| mem_req_addr | output | 32 | Byte address of the word to read |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Read data word |
| res_valid | output | 1 | Translation result valid |
| res_ready | input | 1 | Consumer accepts the result |
| res_paddr | output | 32 | Physical address (0 on fault) |
| res_fault | output | 2 | 0 none, 1 bounds, 2 page invalid |

## Verification
The hardest case to reach from the ports is a base-register write that lands in the middle of a walk. The walk must finish with the old table, and the next request must use the new one. The bench lets a request be accepted and then pulses `base_wr_en` while the memory model is still answering segment reads. It places a different segment entry at the new base, so the two translations give distinguishable frames. The memory model varies `mem_req_ready` and its response latency on a repeating pattern, so each read sees stalls of several lengths. The bench also counts the reads per walk, which shows that a bounds fault never touches the page table.

// File: rtl/segpage_pkg.sv
package segpage_pkg;

  typedef enum logic [1:0] {
    FLT_NONE     = 2'd0,
    FLT_BOUNDS   = 2'd1,
    FLT_PAGE_INV = 2'd2
  } fault_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEGB_REQ,
    ST_SEGB_RSP,
    ST_SEGL_REQ,
    ST_SEGL_RSP,
    ST_PTE_REQ,
    ST_PTE_RSP
  } walk_st_e;

endpackage

// File: rtl/segpage_addr_calc.sv
module segpage_addr_calc #(
  parameter int ADDR_W        = 32,
  parameter int SEG_W         = 8,
  parameter int PAGE_W        = 12,
  parameter int OFF_W         = 12,
  parameter int SEG_ENT_SHIFT = 3,
  parameter int PTE_SHIFT     = 2,
  parameter int WORD_BYTES    = 4
) (
  input  logic [ADDR_W-1:0] tbl_base,
  input  logic [ADDR_W-1:0] laddr,
  input  logic [ADDR_W-1:0] pt_base,
  output logic [ADDR_W-1:0] segb_addr,
  output logic [ADDR_W-1:0] segl_addr,
  output logic [ADDR_W-1:0] pte_addr,
  output logic [PAGE_W-1:0] page_idx,
  output logic [OFF_W-1:0]  offset
);
  localparam int SEG_LSB = OFF_W + PAGE_W;

  logic [SEG_W-1:0]  seg_idx;
  logic [ADDR_W-1:0] seg_ext;
  logic [ADDR_W-1:0] page_ext;

  always_comb begin
    seg_idx   = laddr[SEG_LSB +: SEG_W];
    page_idx  = laddr[OFF_W +: PAGE_W];
    offset    = laddr[OFF_W-1:0];
    seg_ext   = {{(ADDR_W-SEG_W){1'b0}}, seg_idx};
    page_ext  = {{(ADDR_W-PAGE_W){1'b0}}, page_idx};
    segb_addr = tbl_base + (seg_ext << SEG_ENT_SHIFT);
    segl_addr = segb_addr + ADDR_W'(WORD_BYTES);
    pte_addr  = pt_base + (page_ext << PTE_SHIFT);
  end
endmodule

// File: rtl/segpage_walk_ctrl.sv
module segpage_walk_ctrl
  import segpage_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int SEG_W       = 8,
  parameter int PAGE_W      = 12,
  parameter int OFF_W       = 12,
  parameter int FRAME_W     = 20,
  parameter int PTE_VLD_BIT = 31
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [ADDR_W-1:0]  start_laddr,
  input  logic [ADDR_W-1:0]  start_base,
  output logic               idle,
  output logic               mem_req_valid,
  input  logic               mem_req_ready,
  output logic [ADDR_W-1:0]  mem_req_addr,
  input  logic               mem_rsp_valid,
  input  logic [ADDR_W-1:0]  mem_rsp_data,
  output logic               done,
  output fault_e             done_fault,
  output logic [FRAME_W-1:0] done_frame,
  output logic [OFF_W-1:0]   done_offset
);
  walk_st_e          st_q, st_d;
  logic [ADDR_W-1:0] laddr_q, base_q, ptb_q;
  logic [ADDR_W-1:0] segb_addr, segl_addr, pte_addr;
  logic [PAGE_W-1:0] page_idx;
  logic [OFF_W-1:0]  offset;
  logic              rsp_take, out_of_bounds;

  segpage_addr_calc #(
    .ADDR_W (ADDR_W),
    .SEG_W  (SEG_W),
    .PAGE_W (PAGE_W),
    .OFF_W  (OFF_W)
  ) u_calc (
    .tbl_base  (base_q),
    .laddr     (laddr_q),
    .pt_base   (ptb_q),
    .segb_addr (segb_addr),
    .segl_addr (segl_addr),
    .pte_addr  (pte_addr),
    .page_idx  (page_idx),
    .offset    (offset)
  );

  assign rsp_take      = mem_rsp_valid;
  assign out_of_bounds = {{(ADDR_W-PAGE_W){1'b0}}, page_idx} >= mem_rsp_data;
  assign idle          = (st_q == ST_IDLE);
  assign done_offset   = offset;

  always_comb begin
    mem_req_valid = 1'b0;
    mem_req_addr  = '0;
    unique case (st_q)
      ST_SEGB_REQ: begin mem_req_valid = 1'b1; mem_req_addr = segb_addr; end
      ST_SEGL_REQ: begin mem_req_valid = 1'b1; mem_req_addr = segl_addr; end
      ST_PTE_REQ:  begin mem_req_valid = 1'b1; mem_req_addr = pte_addr;  end
      default: ;
    endcase
  end

  always_comb begin
    st_d       = st_q;
    done       = 1'b0;
    done_fault = FLT_NONE;
    done_frame = mem_rsp_data[FRAME_W-1:0];
    unique case (st_q)
      ST_IDLE:     if (start) st_d = ST_SEGB_REQ;
      ST_SEGB_REQ: if (mem_req_ready) st_d = ST_SEGB_RSP;
      ST_SEGB_RSP: if (rsp_take) st_d = ST_SEGL_REQ;
      ST_SEGL_REQ: if (mem_req_ready) st_d = ST_SEGL_RSP;
      ST_SEGL_RSP: if (rsp_take) begin
        if (out_of_bounds) begin
          done       = 1'b1;
          done_fault = FLT_BOUNDS;
          st_d       = ST_IDLE;
        end else begin
          st_d = ST_PTE_REQ;
        end
      end
      ST_PTE_REQ:  if (mem_req_ready) st_d = ST_PTE_RSP;
      ST_PTE_RSP:  if (rsp_take) begin
        done       = 1'b1;
        done_fault = mem_rsp_data[PTE_VLD_BIT] ? FLT_NONE : FLT_PAGE_INV;
        st_d       = ST_IDLE;
      end
      default:     st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      laddr_q <= '0;
      base_q  <= '0;
      ptb_q   <= '0;
    end else begin
      st_q <= st_d;
      if (st_q == ST_IDLE && start) begin
        laddr_q <= start_laddr;
        base_q  <= start_base;
      end
      if (st_q == ST_SEGB_RSP && rsp_take) ptb_q <= mem_rsp_data;
    end
  end
endmodule

// File: rtl/segpage_result_hold.sv
module segpage_result_hold
  import segpage_pkg::*;
#(
  parameter int FRAME_W = 20,
  parameter int OFF_W   = 12,
  localparam int PA_W   = FRAME_W + OFF_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  fault_e             load_fault,
  input  logic [FRAME_W-1:0] load_frame,
  input  logic [OFF_W-1:0]   load_offset,
  output logic               res_valid,
  input  logic               res_ready,
  output logic [PA_W-1:0]    res_paddr,
  output logic [1:0]         res_fault
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_paddr <= '0;
      res_fault <= FLT_NONE;
    end else if (load) begin
      res_valid <= 1'b1;
      res_fault <= load_fault;
      res_paddr <= (load_fault == FLT_NONE) ? {load_frame, load_offset} : '0;
    end else if (res_valid && res_ready) begin
      res_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/segpage_walker.sv
module segpage_walker
  import segpage_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int SEG_W       = 8,
  parameter int PAGE_W      = 12,
  parameter int OFF_W       = 12,
  parameter int FRAME_W     = 20,
  parameter int PTE_VLD_BIT = 31,
  localparam int PA_W       = FRAME_W + OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              base_wr_en,
  input  logic [ADDR_W-1:0] base_wr_data,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_laddr,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [ADDR_W-1:0] mem_rsp_data,
  output logic              res_valid,
  input  logic              res_ready,
  output logic [PA_W-1:0]   res_paddr,
  output logic [1:0]        res_fault
);
  logic [ADDR_W-1:0]  tbl_base_q;
  logic               walk_idle, walk_done;
  fault_e             done_fault;
  logic [FRAME_W-1:0] done_frame;
  logic [OFF_W-1:0]   done_offset;

  always_ff @(posedge clk) begin
    if (!rst_n)          tbl_base_q <= '0;
    else if (base_wr_en) tbl_base_q <= base_wr_data;
  end

  assign req_ready = walk_idle && !res_valid;

  segpage_walk_ctrl #(
    .ADDR_W      (ADDR_W),
    .SEG_W       (SEG_W),
    .PAGE_W      (PAGE_W),
    .OFF_W       (OFF_W),
    .FRAME_W     (FRAME_W),
    .PTE_VLD_BIT (PTE_VLD_BIT)
  ) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (req_valid && req_ready),
    .start_laddr   (req_laddr),
    .start_base    (tbl_base_q),
    .idle          (walk_idle),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_data  (mem_rsp_data),
    .done          (walk_done),
    .done_fault    (done_fault),
    .done_frame    (done_frame),
    .done_offset   (done_offset)
  );

  segpage_result_hold #(
    .FRAME_W (FRAME_W),
    .OFF_W   (OFF_W)
  ) u_hold (
    .clk         (clk),
    .rst_n       (rst_n),
    .load        (walk_done),
    .load_fault  (done_fault),
    .load_frame  (done_frame),
    .load_offset (done_offset),
    .res_valid   (res_valid),
    .res_ready   (res_ready),
    .res_paddr   (res_paddr),
    .res_fault   (res_fault)
  );
endmodule

// File: rtl/segpage_walker_chk.sv
module segpage_walker_chk #(
  parameter int ADDR_W = 32,
  parameter int PA_W   = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic              res_valid,
  input logic              res_ready,
  input logic [PA_W-1:0]   res_paddr,
  input logic [1:0]        res_fault
);
  AST_MEMREQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)); // R3
  AST_NO_READ_WHILE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !mem_req_valid); // R3
  AST_FAULT_ZERO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_fault != 2'd0 |-> res_paddr == '0); // R5
  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready); // R7
  AST_NO_ACCEPT_WITH_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !req_ready); // R7
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_paddr) && $stable(res_fault)); // R8
  AST_FAULT_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> res_fault != 2'd3); // R8
endmodule

bind segpage_walker segpage_walker_chk #(.ADDR_W(ADDR_W), .PA_W(PA_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_valid     (req_valid),
  .req_ready     (req_ready),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_addr  (mem_req_addr),
  .res_valid     (res_valid),
  .res_ready     (res_ready),
  .res_paddr     (res_paddr),
  .res_fault     (res_fault)
);

// File: tb/segpage_walker_tb.sv
`timescale 1ns/1ps
module segpage_walker_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        base_wr_en = 1'b0;
  logic [31:0] base_wr_data = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_laddr = '0;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        res_valid;
  logic        res_ready = 1'b0;
  logic [31:0] res_paddr;
  logic [1:0]  res_fault;

  int n_checks = 0;
  int n_fail   = 0;

  always #10 clk = ~clk;

  segpage_walker u_dut (
    .clk(clk), .rst_n(rst_n), .base_wr_en(base_wr_en), .base_wr_data(base_wr_data),
    .req_valid(req_valid), .req_ready(req_ready), .req_laddr(req_laddr),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .res_valid(res_valid), .res_ready(res_ready), .res_paddr(res_paddr), .res_fault(res_fault)
  );

  // memory model: 1024 words, ready and latency vary on fixed patterns
  logic [31:0] mem [0:1023];
  logic        xfer_q = 1'b0;
  logic [31:0] xaddr_q = '0;
  logic        pend = 1'b0;
  logic [31:0] paddr_pend = '0;
  int          dly = 0, lat = 0, rdy_cnt = 0, nreads = 0;
  logic [31:0] rd_log [0:7];

  always @(posedge clk) begin
    xfer_q  <= mem_req_valid && mem_req_ready;
    xaddr_q <= mem_req_addr;
  end

  always @(negedge clk) begin
    mem_rsp_valid = 1'b0;
    if (rst_n) begin
      if (pend) begin
        if (dly == 0) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_data  = mem[paddr_pend[11:2]];
          pend = 1'b0;
        end else dly = dly - 1;
      end
      if (xfer_q) begin
        pend = 1'b1;
        paddr_pend = xaddr_q;
        dly = lat;
        lat = (lat + 1) % 3;
        rd_log[nreads % 8] = xaddr_q;
        nreads = nreads + 1;
      end
      rdy_cnt = rdy_cnt + 1;
    end
    mem_req_ready = (rdy_cnt % 3) != 2;
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic run_walk(input logic [31:0] la, input int hold, input bit wr_base,
                          input logic [31:0] nb, output logic [31:0] pa,
                          output logic [1:0] ft, output int nr);
    int start_n;
    start_n = nreads;
    @(negedge clk);
    req_valid = 1'b1;
    req_laddr = la;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    check(!req_ready, "R7 ready low during walk", 32'(req_ready), 32'd0);
    if (wr_base) begin
      base_wr_en = 1'b1;
      base_wr_data = nb;
      @(negedge clk);
      base_wr_en = 1'b0;
    end
    while (!res_valid) @(negedge clk);
    pa = res_paddr;
    ft = res_fault;
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      check(res_valid && res_paddr == pa && res_fault == ft && !req_ready,
            "R8 result held under back-pressure", res_paddr, pa);
    end
    res_ready = 1'b1;
    @(negedge clk);
    res_ready = 1'b0;
    check(!res_valid, "R8 result released after handshake", 32'(res_valid), 32'd0);
    nr = nreads - start_n;
  endtask

  // {laddr, expected paddr, expected fault, expected read count}
  localparam logic [67:0] VEC [9] = '{
    {32'h0000_0064, 32'h0000_A064, 2'd0, 2'd3},  // R1 seg0 page0
    {32'h0000_1FFF, 32'hFFFF_FFFF, 2'd0, 2'd3},  // R1 max frame, max offset
    {32'h0000_2000, 32'h0000_0000, 2'd2, 2'd3},  // R5 invalid entry
    {32'h0000_3123, 32'h1234_5123, 2'd0, 2'd3},  // R1 last page in bounds
    {32'h0000_4000, 32'h0000_0000, 2'd1, 2'd2},  // R4 page == length
    {32'h0100_0000, 32'h0000_0000, 2'd1, 2'd2},  // R4 zero-length segment
    {32'h0200_3064, 32'h0000_A064, 2'd0, 2'd3},  // R2 seg2 page3 offset 100
    {32'h0200_F800, 32'h5555_5800, 2'd0, 2'd3},  // R1 seg2 page15
    {32'h0201_0000, 32'h0000_0000, 2'd1, 2'd2}   // R4 seg2 page16
  };

  initial begin
    logic [31:0] pa;
    logic [1:0]  ft;
    int          nr;
    for (int i = 0; i < 1024; i++) mem[i] = 32'h0;
    // segment table at 0x100
    mem[12'h100 >> 2] = 32'h400; mem[12'h104 >> 2] = 32'd4;
    mem[12'h108 >> 2] = 32'h800; mem[12'h10C >> 2] = 32'd0;
    mem[12'h110 >> 2] = 32'hC00; mem[12'h114 >> 2] = 32'd16;
    // alternate segment table at 0x200
    mem[12'h200 >> 2] = 32'h900; mem[12'h204 >> 2] = 32'd1;
    // page tables
    mem[12'h400 >> 2] = 32'h8000_000A;
    mem[12'h404 >> 2] = 32'h800F_FFFF;
    mem[12'h408 >> 2] = 32'h0000_0123;
    mem[12'h40C >> 2] = 32'h8001_2345;
    mem[12'hC0C >> 2] = 32'h8000_000A;
    mem[12'hC3C >> 2] = 32'h8005_5555;
    mem[12'h900 >> 2] = 32'h8007_7777;

    repeat (3) @(negedge clk);
    // R9 reset state
    check(req_ready == 1'b1, "R9 req_ready after reset", 32'(req_ready), 32'd1);
    check(res_valid == 1'b0, "R9 res_valid after reset", 32'(res_valid), 32'd0);
    check(mem_req_valid == 1'b0, "R9 mem_req_valid after reset", 32'(mem_req_valid), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    base_wr_en = 1'b1; base_wr_data = 32'h100;   // R6 load base
    @(negedge clk);
    base_wr_en = 1'b0;

    foreach (VEC[k]) begin
      run_walk(VEC[k][67:36], k % 3, 1'b0, 32'h0, pa, ft, nr);
      check(pa == VEC[k][35:4], "R1 R5 physical address", pa, VEC[k][35:4]);
      check(ft == VEC[k][3:2], "R4 R5 fault code", 32'(ft), 32'(VEC[k][3:2]));
      check(nr == int'(VEC[k][1:0]), "R3 R4 read count", 32'(nr), 32'(VEC[k][1:0]));
    end

    // R2 R3 read addresses and order for segment 2, page 3
    run_walk(32'h0200_3064, 0, 1'b0, 32'h0, pa, ft, nr);
    check(nr == 3, "R3 read count", 32'(nr), 32'd3);
    check(rd_log[(nreads - 3) % 8] == 32'h110, "R2 segment base word address", rd_log[(nreads - 3) % 8], 32'h110);
    check(rd_log[(nreads - 2) % 8] == 32'h114, "R2 segment length word address", rd_log[(nreads - 2) % 8], 32'h114);
    check(rd_log[(nreads - 1) % 8] == 32'hC0C, "R2 page entry address", rd_log[(nreads - 1) % 8], 32'hC0C);

    // R6 base write during walk: current walk uses old base, next uses new
    run_walk(32'h0000_0064, 0, 1'b1, 32'h200, pa, ft, nr);
    check(pa == 32'h0000_A064, "R6 walk keeps captured base", pa, 32'h0000_A064);
    run_walk(32'h0000_0064, 0, 1'b0, 32'h0, pa, ft, nr);
    check(pa == 32'h7777_7064, "R6 next walk uses new base", pa, 32'h7777_7064);
    run_walk(32'h0000_1000, 0, 1'b0, 32'h0, pa, ft, nr);
    check(ft == 2'd1 && nr == 2, "R4 bounds on new table", 32'(ft), 32'd1);

    // R8 long back-pressure
    run_walk(32'h0000_0064, 6, 1'b0, 32'h0, pa, ft, nr);
    check(pa == 32'h7777_7064 && ft == 2'd0, "R8 value after long hold", pa, 32'h7777_7064);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(20 * 100000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule